// File: doc/BRIEF.md
# Dual-Channel Converter Serial Register Front-End

This block is the digital receive side of a two-channel 12-bit converter. A host writes 16-bit words over three pins: an active-low select, a serial clock and a data line. A fast system clock oversamples those pins. Each word carries four program bits and twelve data bits. The program bits choose where the data goes: the channel A code, the channel B code, a holding buffer, or a small control register that selects the reference source.

The holding buffer gives a double-buffered update. The host can preload the next channel B code without moving the output. A later channel A write then copies the buffer into channel B, so both codes change on the same clock edge. Every word also sets the speed-mode and power-down flags. A one-cycle strobe marks each transfer into the output latches.

Top module: `dac_serial_front`

## Requirements
- R1: A falling edge of `csN` opens a frame and empties the shift register. While `csN` is low, each falling edge of `sclk` shifts in `sdata`, first bit received being the most significant.
- R2: In a full frame, bit 15 is the high select bit, bit 14 is the speed bit, bit 13 is the power bit and bit 12 is the low select bit. Bits 11..0 carry the data.
- R3: Select code 00 (high select bit, low select bit) writes the data to both `codeB` and the holding buffer.
- R4: Select code 01 writes only the holding buffer, and `codeB` keeps its value.
- R5: Select code 10 writes the data to `codeA` and, on the same edge, loads `codeB` from the holding buffer.
- R6: Select code 11 writes data bits 1..0 to `refSel` (00 and 11 external, 01 low internal, 10 high internal). Data bits 11..2 are ignored, and `codeA` and `codeB` are unchanged.
- R7: Every transfer sets `fastMode` from the speed bit (1 = fast) and `powerDown` from the power bit (1 = powered down), whatever the select code.
- R8: If `csN` rises after 1 to 15 bits, the partial content is transferred. The received bits sit right-aligned, with zeros above them.
- R9: A frame closed with no clock edge writes nothing. Bits after the sixteenth are ignored until the next `csN` falling edge, and no second transfer follows.
- R10: A transfer takes effect at the fourth system clock edge after the pin edge that ends the frame, that is, the sixteenth `sclk` fall or an early `csN` rise. The pin edge is first sampled at the first of these four edges.
- R11: `updateStb` is high for exactly one cycle per transfer, in the same cycle that the latches take their new values.
- R12: Reset clears both codes, the holding buffer, the control register and both mode flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sdata | input | 1 | Serial data |
| codeA | output | 12 | Channel A output code |
| codeB | output | 12 | Channel B output code |
| fastMode | output | 1 | 1 = fast settling mode |
| powerDown | output | 1 | 1 = power-down requested |
| refSel | output | 2 | Reference source code |
| updateStb | output | 1 | One-cycle pulse on each transfer |

## Verification
A wrong bit count or a missed edge shows up as a misaligned word. The next transfer then routes data to the wrong latch or with shifted bits, and this appears on the code outputs four cycles after the frame ends. A stale holding buffer shows only later, when a channel A write copies it into `codeB`. For that reason the sequences preload the buffer through different paths (select 00, select 01, a partial frame) and then commit it. The bench compares every output with a behavioural model on every cycle, so a stray or doubled strobe is caught in the cycle it occurs.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Strobes handed from the frame control to the datapath
  typedef struct packed {
    logic clearFrame;   // new frame: empty the shift register
    logic shiftBit;     // capture one serial bit
    logic commit;       // move the shift register into the latches
  } dacfe_stb_t;

  // Destination decoded from the two select bits {high, low}
  typedef enum logic [1:0] {
    SEL_B_AND_HOLD = 2'b00,
    SEL_HOLD_ONLY  = 2'b01,
    SEL_A_XFER_B   = 2'b10,
    SEL_CONTROL    = 2'b11
  } dacfe_sel_e;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdata,
  output dacfe_stb_t stb,
  output logic       dataBit
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic csS, sclkS;
  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic commitPend, nextPend;
  logic roomLeft;

  dacfe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csS));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclkSync (
    .clk(clk), .rstN(rstN), .din(sclk), .dout(sclkS));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) dataSync (
    .clk(clk), .rstN(rstN), .din(sdata), .dout(dataBit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkFall = sclkPrev & ~sclkS;
  assign roomLeft = (bitCnt < CNT_FULL);

  always_comb begin
    stb.clearFrame = csFall;
    stb.shiftBit   = ~csS & ~csFall & sclkFall & roomLeft;
    stb.commit     = commitPend;
  end

  // Frame closes on the last bit, or early when select rises mid-frame
  assign nextPend = (stb.shiftBit && bitCnt == CNT_LAST) ||
                    (csRise && bitCnt != '0 && roomLeft);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      commitPend <= 1'b0;
    end else begin
      if (csFall)            bitCnt <= '0;
      else if (stb.shiftBit) bitCnt <= bitCnt + 1'b1;
      commitPend <= nextPend;
    end
  end

endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PROG_W = 4,
  parameter int REF_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacfe_stb_t        stb,
  input  logic              dataBit,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB,
  output logic              fastMode,
  output logic              powerDown,
  output logic [REF_W-1:0]  refSel,
  output logic              updateStb
);

  localparam int FRAME_W  = DATA_W + PROG_W;
  localparam int SEL_HI_B = FRAME_W - 1;
  localparam int SPEED_B  = FRAME_W - 2;
  localparam int POWER_B  = FRAME_W - 3;
  localparam int SEL_LO_B = FRAME_W - 4;

  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  holdReg;
  logic [DATA_W-1:0]  payload;
  dacfe_sel_e         sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (stb.clearFrame) shiftReg <= '0;
    else if (stb.shiftBit)   shiftReg <= {shiftReg[FRAME_W-2:0], dataBit};
  end

  assign payload = shiftReg[DATA_W-1:0];
  assign sel     = dacfe_sel_e'({shiftReg[SEL_HI_B], shiftReg[SEL_LO_B]});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeA     <= '0;
      codeB     <= '0;
      holdReg   <= '0;
      fastMode  <= 1'b0;
      powerDown <= 1'b0;
      refSel    <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= stb.commit;
      if (stb.commit) begin
        fastMode  <= shiftReg[SPEED_B];
        powerDown <= shiftReg[POWER_B];
        unique case (sel)
          SEL_B_AND_HOLD: begin
            codeB   <= payload;
            holdReg <= payload;
          end
          SEL_HOLD_ONLY: holdReg <= payload;
          SEL_A_XFER_B: begin
            codeA <= payload;
            codeB <= holdReg;
          end
          SEL_CONTROL: refSel <= payload[REF_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int PROG_W      = 4,
  parameter int REF_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdata,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB,
  output logic              fastMode,
  output logic              powerDown,
  output logic [REF_W-1:0]  refSel,
  output logic              updateStb
);

  localparam int FRAME_W = DATA_W + PROG_W;

  dacfe_stb_t stb;
  logic       dataBit;

  dacfe_ctrl #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdata(sdata),
    .stb(stb), .dataBit(dataBit));

  dacfe_datapath #(.DATA_W(DATA_W), .PROG_W(PROG_W), .REF_W(REF_W)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataBit(dataBit),
    .codeA(codeA), .codeB(codeB), .fastMode(fastMode),
    .powerDown(powerDown), .refSel(refSel), .updateStb(updateStb));

endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int DATA_W = 12,
  parameter int REF_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] codeA,
  input logic [DATA_W-1:0] codeB,
  input logic              fastMode,
  input logic              powerDown,
  input logic [REF_W-1:0]  refSel,
  input logic              updateStb
);

  // R11
  stb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb);

  // R5
  codeA_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeA) |-> updateStb);

  // R3
  codeB_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeB) |-> updateStb);

  // R6
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refSel) |-> updateStb);

  // R7
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({fastMode, powerDown}) |-> updateStb);

endmodule

bind dac_serial_front dac_serial_front_chk #(.DATA_W(DATA_W), .REF_W(REF_W)) chkInst (.*);

// File: tb/dac_serial_front_test.sv
module dac_serial_front_test;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic sdata = 1'b0;
  logic [11:0] codeA, codeB;
  logic fastMode, powerDown, updateStb;
  logic [1:0] refSel;

  int errors = 0;
  int checks = 0;
  int stbCount = 0;

  // behavioural model state
  int mA, mB, mHold, mFast, mPd, mRef, mStb, mShift, mCnt, mPend;
  int qCs[$], qSk[$], qD[$];

  always #5 clk = ~clk;

  dac_serial_front uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdata(sdata),
    .codeA(codeA), .codeB(codeB), .fastMode(fastMode),
    .powerDown(powerDown), .refSel(refSel), .updateStb(updateStb));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mA = 0; mB = 0; mHold = 0; mFast = 0; mPd = 0; mRef = 0; mStb = 0;
    mShift = 0; mCnt = 0; mPend = 0;
    qCs = '{1, 1, 1}; qSk = '{1, 1, 1}; qD = '{0, 0, 0};
  endtask

  // pins reach the frame logic two edges late; edges judged on the last two
  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int csNow, csOld, skNow, skOld, dNow, sel, dat;
      csNow = qCs[1]; csOld = qCs[2]; skNow = qSk[1]; skOld = qSk[2]; dNow = qD[1];
      mStb = 0;
      if (mPend == 1) begin
        mStb = 1;
        mFast = (mShift >> 14) & 1;
        mPd = (mShift >> 13) & 1;
        sel = ((mShift >> 14) & 2) | ((mShift >> 12) & 1);
        dat = mShift & 'hFFF;
        case (sel)
          0: begin mB = dat; mHold = dat; end
          1: mHold = dat;
          2: begin mA = dat; mB = mHold; end
          default: mRef = dat & 3;
        endcase
        mPend = 0;
      end
      if (csOld == 1 && csNow == 0) begin
        mShift = 0; mCnt = 0;
      end else if (csOld == 0 && csNow == 1) begin
        if (mCnt > 0 && mCnt < 16) mPend = 1;
      end else if (csNow == 0 && skOld == 1 && skNow == 0 && mCnt < 16) begin
        mShift = ((mShift << 1) | dNow) & 'hFFFF;
        mCnt++;
        if (mCnt == 16) mPend = 1;
      end
      qCs.push_front(int'(csN)); void'(qCs.pop_back());
      qSk.push_front(int'(sclk)); void'(qSk.pop_back());
      qD.push_front(int'(sdata)); void'(qD.pop_back());
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 codeA vs model", int'(codeA), mA);
      check("R3 codeB vs model", int'(codeB), mB);
      check("R7 fastMode vs model", int'(fastMode), mFast);
      check("R7 powerDown vs model", int'(powerDown), mPd);
      check("R6 refSel vs model", int'(refSel), mRef);
      check("R11 updateStb vs model", int'(updateStb), mStb);
      if (updateStb) stbCount++;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftOut(logic [31:0] bits, int n, bit latChk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sdata = bits[n-1-i];
      waitClk(HALF);
      sclk = 1'b0;
      if (latChk && i == 15) begin
        for (int k = 1; k <= 4; k++) begin
          @(negedge clk);
          check("R10 transfer latency", int'(updateStb), (k == 4) ? 1 : 0);
        end
      end else waitClk(HALF);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(logic [31:0] bits, int n, bit latChk);
    @(negedge clk) csN = 1'b0;
    waitClk(3);
    shiftOut(bits, n, latChk);
    waitClk(2);
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    int base;
    modelReset();
    waitClk(4);
    // R12: everything cleared under reset
    check("R12 codeA reset", int'(codeA), 0);
    check("R12 codeB reset", int'(codeB), 0);
    check("R12 flags reset", int'({fastMode, powerDown, refSel}), 0);
    check("R12 strobe reset", int'(updateStb), 0);
    rstN = 1'b1;
    waitClk(4);

    // R6 R7: control word, high ref, junk in ignored bits, fast mode
    frame(32'hDFF6, 16, 0);
    check("R6 refSel high internal", int'(refSel), 2);
    check("R6 codes untouched", int'({codeA, codeB}), 0);
    check("R7 fast mode set", int'(fastMode), 1);

    // R3 R1 R2: channel B plus buffer
    frame(32'h45A3, 16, 0);
    check("R3 codeB written", int'(codeB), 'h5A3);
    check("R3 codeA unchanged", int'(codeA), 0);

    // R4 R7: buffer only, power down, slow
    frame(32'h3123, 16, 0);
    check("R4 codeB held", int'(codeB), 'h5A3);
    check("R7 power down", int'(powerDown), 1);
    check("R7 slow mode", int'(fastMode), 0);
    check("R6 refSel kept", int'(refSel), 2);

    // R5 R10: channel A write commits buffer to B
    frame(32'hCABC, 16, 1);
    check("R5 codeA written", int'(codeA), 'hABC);
    check("R5 codeB from buffer", int'(codeB), 'h123);
    check("R7 power up again", int'(powerDown), 0);

    // R9: aborted frame with no clock
    base = stbCount;
    @(negedge clk) csN = 1'b0;
    waitClk(6);
    csN = 1'b1;
    waitClk(10);
    check("R9 abort no strobe", stbCount - base, 0);
    check("R9 abort codes kept", int'({codeA, codeB}), 'hABC123);

    // R9: overrun, extra bits ignored, single transfer
    base = stbCount;
    frame({12'h0, 16'h0F0F, 4'hA}, 20, 0);
    check("R9 overrun codeB", int'(codeB), 'hF0F);
    check("R9 overrun one strobe", stbCount - base, 1);

    // R8: partial frame of six bits
    base = stbCount;
    frame(32'h2D, 6, 0);
    check("R8 partial codeB", int'(codeB), 'h02D);
    check("R8 partial strobe", stbCount - base, 1);
    check("R8 partial flags", int'({fastMode, powerDown}), 0);

    // R5: buffer loaded by partial frame now committed
    frame(32'h8111, 16, 0);
    check("R5 second A write", int'(codeA), 'h111);
    check("R5 buffer from partial", int'(codeB), 'h02D);

    // R6: remaining reference codes
    frame(32'hD001, 16, 0);
    check("R6 refSel low internal", int'(refSel), 1);
    frame(32'hDFFF, 16, 0);
    check("R6 refSel code 11", int'(refSel), 3);
    check("R6 codes still", int'({codeA, codeB}), 'h11102D);

    waitClk(4);
    summary();
    $finish;
  end

endmodule